// File: doc/BRIEF.md
# Multi-Transition Delay-Line Timestamp Encoder

This block sits behind a register bank that samples a tapped delay line on every system clock. It takes one snapshot of the taps per cycle, removes single-tap sampling bubbles, and looks for the level changes that a launched edge pattern leaves along the line. Each launched pattern carries more than one transition. The block adds the positions of all of them into one fine code. This gives about twice as many virtual bins as a single thermometer edge would, and the bins are spread more evenly.

The channel runs continuously and needs no trigger. A hit is declared in the first cycle in which the filtered snapshot shows motion after a quiet snapshot. The block then forms a record. The record holds the free-running coarse count (corrected by one when a transition sits at either end of the line), the summed fine code, the edge polarity and a fixed channel number. The record leaves on a valid/ready output. Downstream logic forms the time as coarse minus fine, and forms channel differences as the coarse difference minus the fine difference. Pairs of rising and falling records give time over threshold. A hit that arrives while a record is still waiting is dropped, and a sticky overflow flag is set.

Top module: `tdc_wu_encoder`

## Requirements
- R1: A synchronous active-high reset clears the record valid, the overflow flag, the coarse counter and the previous-snapshot activity state. A hit sampled on the first clock edge after reset is released is stamped with coarse 0.
- R2: The coarse counter advances by one on every clock edge outside reset and wraps modulo 2^COARSE_W. The coarse field of a record is the counter value at the edge that sampled the hit (0 for the first edge after reset), before any correction.
- R3: Before decoding, every interior tap whose two neighbours agree with each other takes their value. Tap 0 and tap TAPS-1 are never altered. A quiet line with one isolated flipped tap produces no hit, and such a bubble next to real transitions does not change the fine code.
- R4: A transition at position i means that filtered taps i and i+1 differ, for i from 0 to TAPS-2. The fine field is the sum of i over all transitions in the hit snapshot.
- R5: A hit is a sampled snapshot whose filtered vector has at least one transition while the previous filtered snapshot had none. Its record is valid from the clock edge that sampled it. A second moving snapshot that directly follows another one is not a new hit.
- R6: The polarity field is the value of filtered tap 0 in the hit snapshot: 1 marks a rising edge and 0 marks a falling edge.
- R7: When a transition lies at position TAPS-2, the coarse field is the sampled count minus 1. Otherwise, when a transition lies at position 0, the coarse field is the count plus 1. Both results wrap modulo 2^COARSE_W.
- R8: While valid is high and ready is low, the record fields stay unchanged. After an edge with valid and ready both high, valid is low unless a new hit was sampled on that edge.
- R9: A hit sampled while valid is high and ready is low is discarded. The pending record is kept, and the overflow output goes high and stays high until reset.
- R10: The channel field of every record equals the CHAN_ID parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; the taps are sampled on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| taps_i | input | TAPS | Registered delay-line snapshot, tap 0 nearest the input |
| rec_valid_o | output | 1 | A timestamp record is offered |
| rec_ready_i | input | 1 | Downstream accepts the record this cycle |
| rec_coarse_o | output | COARSE_W | Corrected coarse count |
| rec_fine_o | output | FINE_W | Sum of transition positions |
| rec_rising_o | output | 1 | Edge polarity, 1 = rising |
| rec_chan_o | output | CHAN_W | Channel number |
| overflow_o | output | 1 | Sticky flag: a hit was lost to back-pressure |

## Verification
Assertions check on every cycle that the coarse counter steps by one, that a stalled record keeps its fields and its valid, that valid rises only after a detected hit, and that a hit under stall sets the overflow flag, which then never falls. The values themselves can only be shown by the bench scenarios. These are the fine sums for every placement of one and of two transitions in a 16-tap line with both polarities, the end-of-line coarse corrections across counter wrap, bubble immunity, the rejection of back-to-back moving snapshots, and the first stamp after reset.

// File: rtl/tdc_wu_pkg.sv
package tdc_wu_pkg;

  typedef enum logic [1:0] {
    CORR_NONE = 2'd0,
    CORR_INC  = 2'd1,
    CORR_DEC  = 2'd2
  } corr_e;

  // Width that holds the sum of every transition position 0..taps-2.
  function automatic int fine_width(input int taps);
    return $clog2((taps * (taps - 1)) / 2 + 1);
  endfunction

  // End-of-line correction: a transition at the far end wins over one at the near end.
  function automatic corr_e pick_corr(input logic at_first, input logic at_last);
    if (at_last)       return CORR_DEC;
    else if (at_first) return CORR_INC;
    else               return CORR_NONE;
  endfunction

endpackage

// File: rtl/tdc_bubble_filter.sv
module tdc_bubble_filter #(
  parameter int TAPS = 256
) (
  input  logic [TAPS-1:0] raw_i,
  output logic [TAPS-1:0] clean_o
);
  // R3: an interior tap that disagrees with two agreeing neighbours is overruled.
  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    if (i == 0 || i == TAPS - 1) begin : g_end
      assign clean_o[i] = raw_i[i];
    end else begin : g_mid
      assign clean_o[i] = (raw_i[i-1] == raw_i[i+1]) ? raw_i[i-1] : raw_i[i];
    end
  end
endmodule

// File: rtl/tdc_transition_scan.sv
module tdc_transition_scan #(
  parameter int TAPS   = 256,
  parameter int FINE_W = 15
) (
  input  logic [TAPS-1:0]   line_i,
  output logic              moving_o,
  output logic [FINE_W-1:0] pos_sum_o,
  output logic              at_first_o,
  output logic              at_last_o,
  output logic              head_level_o
);
  localparam int NPOS = TAPS - 1;

  logic [NPOS-1:0] edge_w;

  for (genvar i = 0; i < NPOS; i++) begin : g_edge
    assign edge_w[i] = line_i[i] ^ line_i[i+1];
  end

  // R4: add the index of every transition.
  always_comb begin
    pos_sum_o = '0;
    for (int i = 0; i < NPOS; i++) begin
      if (edge_w[i]) pos_sum_o = pos_sum_o + FINE_W'(i);
    end
  end

  assign moving_o     = |edge_w;
  assign at_first_o   = edge_w[0];
  assign at_last_o    = edge_w[NPOS-1];
  assign head_level_o = line_i[0];
endmodule

// File: rtl/tdc_coarse_counter.sv
module tdc_coarse_counter #(
  parameter int W = 28
) (
  input  logic         clk_i,
  input  logic         rst_i,
  output logic [W-1:0] count_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) count_o <= '0;
    else       count_o <= count_o + 1'b1;
  end

  // R2: one step per clock outside reset, with wrap.
  a_r2_coarse_step: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) |-> count_o == $past(count_o) + 1'b1);
endmodule

// File: rtl/tdc_wu_encoder.sv
module tdc_wu_encoder #(
  parameter int TAPS     = 256,
  parameter int COARSE_W = 28,
  parameter int CHAN_W   = 6,
  parameter int CHAN_ID  = 0,
  localparam int FINE_W  = tdc_wu_pkg::fine_width(TAPS)
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic [TAPS-1:0]     taps_i,
  output logic                rec_valid_o,
  input  logic                rec_ready_i,
  output logic [COARSE_W-1:0] rec_coarse_o,
  output logic [FINE_W-1:0]   rec_fine_o,
  output logic                rec_rising_o,
  output logic [CHAN_W-1:0]   rec_chan_o,
  output logic                overflow_o
);
  import tdc_wu_pkg::*;

  localparam logic [CHAN_W-1:0] CHAN_VAL = CHAN_W'(CHAN_ID);

  logic [TAPS-1:0]     clean_w;
  logic                moving_w;
  logic [FINE_W-1:0]   pos_sum_w;
  logic                at_first_w;
  logic                at_last_w;
  logic                head_w;
  logic [COARSE_W-1:0] count_w;
  logic [COARSE_W-1:0] stamp_w;
  corr_e               corr_w;
  logic                prev_moving_q;

  // Named events for the assertions.
  logic hit_w;
  logic slot_free_w;
  logic take_w;
  logic drop_w;

  tdc_bubble_filter #(.TAPS(TAPS)) u_filter (
    .raw_i   (taps_i),
    .clean_o (clean_w)
  );

  tdc_transition_scan #(.TAPS(TAPS), .FINE_W(FINE_W)) u_scan (
    .line_i       (clean_w),
    .moving_o     (moving_w),
    .pos_sum_o    (pos_sum_w),
    .at_first_o   (at_first_w),
    .at_last_o    (at_last_w),
    .head_level_o (head_w)
  );

  tdc_coarse_counter #(.W(COARSE_W)) u_coarse (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .count_o (count_w)
  );

  // R7: end-of-line coarse correction.
  assign corr_w = pick_corr(at_first_w, at_last_w);
  always_comb begin
    unique case (corr_w)
      CORR_INC: stamp_w = count_w + 1'b1;
      CORR_DEC: stamp_w = count_w - 1'b1;
      default:  stamp_w = count_w;
    endcase
  end

  // R5: motion after a quiet snapshot is a hit.
  assign hit_w       = moving_w && !prev_moving_q;
  assign slot_free_w = !rec_valid_o || rec_ready_i;
  assign take_w      = hit_w && slot_free_w;
  assign drop_w      = hit_w && !slot_free_w;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      prev_moving_q <= 1'b0;
      rec_valid_o   <= 1'b0;
      overflow_o    <= 1'b0;
      rec_coarse_o  <= '0;
      rec_fine_o    <= '0;
      rec_rising_o  <= 1'b0;
      rec_chan_o    <= '0;
    end else begin
      prev_moving_q <= moving_w;
      if (take_w) begin
        rec_valid_o  <= 1'b1;
        rec_coarse_o <= stamp_w;
        rec_fine_o   <= pos_sum_w;
        rec_rising_o <= head_w;
        rec_chan_o   <= CHAN_VAL;
      end else if (rec_ready_i) begin
        rec_valid_o  <= 1'b0;
      end
      if (drop_w) overflow_o <= 1'b1;
    end
  end

  // R8: a stalled record holds.
  a_r8_stall_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    rec_valid_o && !rec_ready_i |=> rec_valid_o && $stable(rec_coarse_o)
      && $stable(rec_fine_o) && $stable(rec_rising_o) && $stable(rec_chan_o));

  // R5: valid only rises after a detected hit.
  a_r5_valid_source: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(rec_valid_o) |-> $past(hit_w));

  // R9: a hit under stall raises overflow.
  a_r9_drop_flags: assert property (@(posedge clk_i) disable iff (rst_i)
    hit_w && rec_valid_o && !rec_ready_i |=> overflow_o);

  // R9: overflow is sticky.
  a_r9_overflow_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
    overflow_o |=> overflow_o);
endmodule

// File: tb/sim_tdc_wu_encoder.sv
module sim_tdc_wu_encoder;
  localparam int CLK_PERIOD = 10;
  localparam int TAPS = 16;
  localparam int CW   = 8;
  localparam int HW   = 4;
  localparam int CID  = 5;
  localparam int FW   = 7;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [TAPS-1:0] taps = '0;
  logic            ready = 1'b1;
  logic            valid;
  logic [CW-1:0]   coarse;
  logic [FW-1:0]   fine;
  logic            rising;
  logic [HW-1:0]   chan;
  logic            ovf;

  int checks = 0;
  int fails  = 0;
  logic [CW-1:0] cyc = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Bench model of the free-running count (R2).
  always @(posedge clk) begin
    if (rst) cyc <= '0;
    else     cyc <= cyc + 1'b1;
  end

  tdc_wu_encoder #(.TAPS(TAPS), .COARSE_W(CW), .CHAN_W(HW), .CHAN_ID(CID)) u0 (
    .clk_i(clk), .rst_i(rst), .taps_i(taps),
    .rec_valid_o(valid), .rec_ready_i(ready),
    .rec_coarse_o(coarse), .rec_fine_o(fine), .rec_rising_o(rising),
    .rec_chan_o(chan), .overflow_o(ovf)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Line with the new level at tap 0 and toggles after positions a (and b).
  function automatic logic [TAPS-1:0] pattern(input bit lvl, input int a, input int b, input bit two);
    logic [TAPS-1:0] v;
    bit cur = lvl;
    for (int i = 0; i < TAPS; i++) begin
      v[i] = cur;
      if (i == a || (two && i == b)) cur = ~cur;
    end
    return v;
  endfunction

  function automatic logic [CW-1:0] expect_coarse(input logic [CW-1:0] c, input int a, input int b, input bit two);
    if (a == TAPS-2 || (two && b == TAPS-2)) return c - 1'b1;
    if (a == 0) return c + 1'b1;
    return c;
  endfunction

  // Present one hit with ready high, check the record, then a quiet cycle.
  task automatic one_hit(input bit lvl, input int a, input int b, input bit two, input logic [TAPS-1:0] extra);
    logic [CW-1:0] ec;
    int ef;
    @(negedge clk);
    taps = pattern(lvl, a, b, two) ^ extra;
    ec = expect_coarse(cyc, a, b, two);
    ef = two ? a + b : a;
    @(negedge clk);
    chk(valid == 1'b1, "R5 valid after hit", int'(valid), 1);
    chk(fine == FW'(ef), "R4 fine sum", int'(fine), ef);
    chk(coarse == ec, "R2/R7 coarse", int'(coarse), int'(ec));
    chk(rising == lvl, "R6 polarity", int'(rising), int'(lvl));
    chk(chan == HW'(CID), "R10 channel", int'(chan), CID);
    taps = {TAPS{lvl}};
    @(negedge clk);
    chk(valid == 1'b0, "R8 valid drops after accept", int'(valid), 0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : stim
    logic [CW-1:0] held_c;
    repeat (3) @(negedge clk);
    chk(valid == 1'b0, "R1 valid in reset", int'(valid), 0);
    chk(ovf == 1'b0, "R1 overflow in reset", int'(ovf), 0);
    rst = 1'b0;
    // R1: hit on first edge after reset release, stamp 0.
    taps = pattern(1'b1, 5, 0, 1'b0);
    @(negedge clk);
    chk(valid && coarse == 0, "R1 first stamp", int'(coarse), 0);
    taps = '1;
    @(negedge clk);

    // R4/R6/R7: every single transition, both polarities.
    for (int p = 0; p < TAPS-1; p++)
      for (int l = 0; l < 2; l++) one_hit(l[0], p, 0, 1'b0, '0);

    // R4: every pair with a middle segment of at least two taps.
    for (int a = 0; a < TAPS-1; a++)
      for (int b = a + 2; b < TAPS-1; b++)
        for (int l = 0; l < 2; l++) one_hit(l[0], a, b, 1'b1, '0);

    // R3: isolated bubbles in a quiet line give no hit.
    @(negedge clk);
    taps = 16'h0080;
    @(negedge clk);
    chk(valid == 1'b0, "R3 bubble in low line", int'(valid), 0);
    taps = 16'hFFF7;
    @(negedge clk);
    chk(valid == 1'b0, "R3 bubble in high line", int'(valid), 0);
    taps = '1;
    @(negedge clk);
    // R3: a bubble beside real transitions leaves the fine sum unchanged.
    one_hit(1'b1, 3, 9, 1'b1, 16'h1000);

    // R5: two moving snapshots in a row make one record.
    @(negedge clk);
    taps = pattern(1'b0, 6, 0, 1'b0);
    @(negedge clk);
    chk(valid == 1'b1, "R5 first moving snapshot", int'(valid), 1);
    taps = pattern(1'b0, 8, 0, 1'b0);
    @(negedge clk);
    chk(valid == 1'b0, "R5 second moving snapshot ignored", int'(valid), 0);
    taps = '0;
    @(negedge clk);

    // R8/R9: back-pressure.
    ready = 1'b0;
    taps = pattern(1'b1, 4, 0, 1'b0);
    held_c = cyc;
    @(negedge clk);
    taps = '1;
    @(negedge clk);
    @(negedge clk);
    chk(valid == 1'b1 && fine == 4, "R8 record held under stall", int'(fine), 4);
    chk(ovf == 1'b0, "R9 no overflow yet", int'(ovf), 0);
    taps = pattern(1'b0, 10, 0, 1'b0);
    @(negedge clk);
    taps = '0;
    chk(ovf == 1'b1, "R9 overflow set on drop", int'(ovf), 1);
    chk(fine == 4 && coarse == held_c, "R9 pending record kept", int'(fine), 4);
    chk(rising == 1'b1, "R9 pending polarity kept", int'(rising), 1);
    ready = 1'b1;
    @(negedge clk);
    chk(valid == 1'b0, "R8 accepted after stall", int'(valid), 0);
    chk(ovf == 1'b1, "R9 overflow sticky", int'(ovf), 1);
    rst = 1'b1;
    @(negedge clk);
    chk(ovf == 1'b0, "R1 overflow cleared by reset", int'(ovf), 0);
    rst = 1'b0;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule